// File: doc/BRIEF.md
# Sign-Edge Down Counter with Sticky Exception

This block is a down counter with a software write port and a read port. It drops by one on each time-base tick enable. It raises a level exception whenever the top bit of the count goes from clear to set. That happens in two ways: the count wraps from zero to all ones on a tick, or software writes a value with the top bit set over a count whose top bit is clear. There is no terminal-count compare and no automatic reload. After a wrap the counter keeps running down from all ones.

The exception is held by a two-state machine. The states are `EXC_IDLE` and `EXC_PENDING`. Transition `T_RAISE` (`EXC_IDLE` to `EXC_PENDING`) is taken on any expiry event. Transition `T_CLEAR` (`EXC_PENDING` to `EXC_IDLE`) is taken on an acknowledge pulse in a cycle with no new expiry. In every other case the state holds. A second copy of the block can serve as a hypervisor counter. The `ENABLE` parameter removes an instance's function entirely: a disabled instance reads as all ones, ignores writes and never raises the exception.

A time-base rate change is signalled on `rate_reload`. It reloads all ones without raising anything.

Top module: `sign_edge_decrementer`

## Requirements
- R1: After reset, `count_o` reads all ones (0xFFFFFFFF) and `exc_o` is low.
- R2: A cycle with `tick` high and neither `wr_en` nor `rate_reload` lowers `count_o` by one on the next cycle; `count_o` always reads the current count.
- R3: A tick taken while the count is 0x00000000 makes it 0xFFFFFFFF and sets `exc_o` on the next cycle, and counting continues from 0xFFFFFFFF with no reload.
- R4: A write whose data has bit 31 set, over a count whose bit 31 is clear, loads the data and sets `exc_o` on the next cycle.
- R5: A write whose data has bit 31 clear, or any write over a count whose bit 31 is already set, loads the data and raises no exception.
- R6: `rate_reload` loads 0xFFFFFFFF, raises no exception, and takes priority over a write and a tick in the same cycle; an exception already pending stays pending.
- R7: When `wr_en` and `tick` are high in the same cycle, the written value is loaded and that tick is dropped; the exception rule of R4/R5 still applies.
- R8: `exc_o` stays high until `ack` is pulsed; an `ack` in the same cycle as a new expiry leaves `exc_o` high.
- R9: With `ENABLE` = 0, `count_o` stays 0xFFFFFFFF and `exc_o` stays low whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable; count down by one |
| rate_reload | input | 1 | Time-base rate changed; reload all ones |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | W | Value to load |
| ack | input | 1 | Exception acknowledge pulse |
| count_o | output | W | Current remaining count |
| exc_o | output | 1 | Sticky exception level |

## Verification
Several pairs of functions can fall in the same cycle. The pair that matters most is a fresh expiry (a wrap or a sign-edge write) together with the acknowledge that clears the exception. The bench provokes this by loading zero, then applying a tick and `ack` together. It judges the result by requiring `exc_o` to still be high and the count to be all ones on the next cycle.

The write-versus-tick and reload-versus-write collisions are driven the same way. In each case the loaded value must show that the lower-priority request was dropped.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic [0:0] {
        EXC_IDLE    = 1'b0,
        EXC_PENDING = 1'b1
    } exc_state_t;
endpackage

// File: rtl/dec_next.sv
// Next-count selection and expiry detection for the sign-edge counter.
module dec_next #(
    parameter int W = 32
) (
    input  logic [W-1:0] cnt,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rate_reload,
    output logic [W-1:0] nxt,
    output logic         expiry
);
    localparam int MSB = W - 1;

    typedef enum logic [1:0] {
        OP_HOLD, OP_TICK, OP_WRITE, OP_RELOAD
    } op_t;

    op_t op;

    // Priority: rate reload, then write, then tick.
    always_comb begin
        if (rate_reload)  op = OP_RELOAD;
        else if (wr_en)   op = OP_WRITE;
        else if (tick)    op = OP_TICK;
        else              op = OP_HOLD;
    end

    always_comb begin
        nxt    = cnt;
        expiry = 1'b0;
        unique case (op)
            OP_RELOAD: nxt = '1;
            OP_WRITE: begin
                nxt    = wr_data;
                expiry = wr_data[MSB] & ~cnt[MSB];
            end
            OP_TICK: begin
                nxt    = cnt - 1'b1;
                expiry = (cnt == '0);
            end
            OP_HOLD: nxt = cnt;
        endcase
    end
endmodule

// File: rtl/dec_exc_fsm.sv
// Sticky exception state machine: a raise wins over an acknowledge.
module dec_exc_fsm
    import dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expiry,
    input  logic ack,
    output logic exc
);
    exc_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EXC_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EXC_IDLE:    if (expiry)      state_nxt = EXC_PENDING; // T_RAISE
            EXC_PENDING: if (ack && !expiry) state_nxt = EXC_IDLE; // T_CLEAR
        endcase
    end

    always_comb begin
        exc = (state == EXC_PENDING);
    end
endmodule

// File: rtl/sign_edge_decrementer.sv
module sign_edge_decrementer #(
    parameter int W      = 32,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         rate_reload,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         ack,
    output logic [W-1:0] count_o,
    output logic         exc_o
);
    generate
        if (ENABLE) begin : g_on
            logic [W-1:0] cnt_q;
            logic [W-1:0] cnt_d;
            logic         expiry;

            dec_next #(.W(W)) u_next (
                .cnt        (cnt_q),
                .tick       (tick),
                .wr_en      (wr_en),
                .wr_data    (wr_data),
                .rate_reload(rate_reload),
                .nxt        (cnt_d),
                .expiry     (expiry)
            );

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '1;
                else        cnt_q <= cnt_d;
            end

            dec_exc_fsm u_fsm (
                .clk   (clk),
                .rst_n (rst_n),
                .expiry(expiry),
                .ack   (ack),
                .exc   (exc_o)
            );

            assign count_o = cnt_q;
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, tick, rate_reload, wr_en, wr_data, ack};
            assign count_o = '1;
            assign exc_o   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
    parameter int W      = 32,
    parameter bit ENABLE = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         rate_reload,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         ack,
    input logic [W-1:0] count_o,
    input logic         exc_o
);
    generate
        if (ENABLE) begin : g_chk
            p_tick_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick && !wr_en && !rate_reload |=> count_o == $past(count_o) - 1'b1);

            p_wrap_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick && !wr_en && !rate_reload && count_o == '0 |=> exc_o && count_o == '1);

            p_sign_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && !rate_reload && wr_data[W-1] && !count_o[W-1]
                |=> exc_o && count_o == $past(wr_data));

            p_quiet_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && !rate_reload && (!wr_data[W-1] || count_o[W-1]) && !exc_o
                |=> !exc_o && count_o == $past(wr_data));

            p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
                rate_reload && !exc_o |=> !exc_o && count_o == '1);

            p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && tick && !rate_reload |=> count_o == $past(wr_data));

            p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                exc_o && !ack |=> exc_o);
        end else begin : g_chk_off
            p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !exc_o && count_o == '1);
        end
    endgenerate
endmodule

bind sign_edge_decrementer dec_checker #(.W(W), .ENABLE(ENABLE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rate_reload(rate_reload),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ack        (ack),
    .count_o    (count_o),
    .exc_o      (exc_o)
);

// File: tb/sign_edge_decrementer_tb.sv
module sign_edge_decrementer_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0, rate_reload = 1'b0, wr_en = 1'b0, ack = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o, off_cnt;
    logic         exc_o, off_exc;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    sign_edge_decrementer #(.W(W), .ENABLE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate_reload(rate_reload),
        .wr_en(wr_en), .wr_data(wr_data), .ack(ack),
        .count_o(count_o), .exc_o(exc_o)
    );

    sign_edge_decrementer #(.W(W), .ENABLE(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate_reload(rate_reload),
        .wr_en(wr_en), .wr_data(wr_data), .ack(ack),
        .count_o(off_cnt), .exc_o(off_exc)
    );

    typedef struct packed {
        logic        rl;
        logic        wr;
        logic        tk;
        logic        ak;
        logic [31:0] dat;
        logic [31:0] ecnt;
        logic        eexc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0, 32'h0000_0003, 32'h0000_0003, 1'b0, 4'd5}, // R5 clear MSB write
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'h0000_0002, 1'b0, 4'd2}, // R2
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'h0000_0001, 1'b0, 4'd2}, // R2
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'h0000_0000, 1'b0, 4'd2}, // R2
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'hFFFF_FFFF, 1'b1, 4'd3}, // R3 wrap
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'hFFFF_FFFE, 1'b1, 4'd8}, // R8 sticky
        '{1'b0,1'b0,1'b0,1'b1, 32'h0,         32'hFFFF_FFFE, 1'b0, 4'd8}, // R8 ack clears
        '{1'b0,1'b1,1'b0,1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'd5}, // R5 old MSB set
        '{1'b0,1'b1,1'b0,1'b0, 32'h0000_0010, 32'h0000_0010, 1'b0, 4'd5}, // R5
        '{1'b0,1'b1,1'b0,1'b0, 32'h8000_0005, 32'h8000_0005, 1'b1, 4'd4}, // R4 sign edge
        '{1'b0,1'b0,1'b0,1'b1, 32'h0,         32'h8000_0005, 1'b0, 4'd8}, // R8
        '{1'b0,1'b1,1'b0,1'b0, 32'h0000_0007, 32'h0000_0007, 1'b0, 4'd5}, // R5
        '{1'b0,1'b1,1'b1,1'b0, 32'h0000_0020, 32'h0000_0020, 1'b0, 4'd7}, // R7 write beats tick
        '{1'b0,1'b1,1'b0,1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd5}, // R5
        '{1'b0,1'b0,1'b1,1'b1, 32'h0,         32'hFFFF_FFFF, 1'b1, 4'd8}, // R8 expiry beats ack
        '{1'b0,1'b0,1'b0,1'b1, 32'h0,         32'hFFFF_FFFF, 1'b0, 4'd8}, // R8
        '{1'b1,1'b1,1'b1,1'b0, 32'h0000_0005, 32'hFFFF_FFFF, 1'b0, 4'd6}, // R6 reload wins
        '{1'b0,1'b0,1'b1,1'b0, 32'h0,         32'hFFFF_FFFE, 1'b0, 4'd2}  // R2
    };

    task automatic chk(input string what, input int req,
                       input logic [W-1:0] ac, input logic [W-1:0] ec,
                       input logic ae, input logic ee);
        checks++;
        if (ac !== ec || ae !== ee) begin
            errors++;
            $display("FAIL R%0d %s: count=%h exc=%b expected count=%h exc=%b",
                     req, what, ac, ae, ec, ee);
        end
    endtask

    task automatic step(input logic rl, input logic wr, input logic tk,
                        input logic ak, input logic [W-1:0] d);
        @(negedge clk);
        rate_reload = rl; wr_en = wr; tick = tk; ack = ak; wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("reset state", 1, count_o, 32'hFFFF_FFFF, exc_o, 1'b0); // R1
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].rl, TBL[i].wr, TBL[i].tk, TBL[i].ak, TBL[i].dat);
            chk($sformatf("vector %0d", i), int'(TBL[i].req), count_o, TBL[i].ecnt,
                exc_o, TBL[i].eexc);
            chk($sformatf("disabled copy at vector %0d", i), 9, off_cnt, 32'hFFFF_FFFF,
                off_exc, 1'b0); // R9
        end

        // R6: reload leaves a pending exception pending
        step(0, 1, 0, 0, 32'h0);
        step(0, 0, 1, 0, 32'h0);
        step(0, 0, 1, 0, 32'h0);
        step(1, 0, 0, 0, 32'h0);
        chk("reload keeps pending", 6, count_o, 32'hFFFF_FFFF, exc_o, 1'b1);
        step(0, 0, 0, 1, 32'h0);
        chk("ack after reload", 8, count_o, 32'hFFFF_FFFF, exc_o, 1'b0);

        // R7 with R4: sign-edge write colliding with a tick
        step(0, 1, 0, 0, 32'h0000_0004);
        step(0, 1, 1, 0, 32'h8000_0000);
        chk("edge write with tick", 7, count_o, 32'h8000_0000, exc_o, 1'b1);

        // R3: counting continues below all ones after a wrap, no reload
        step(0, 0, 0, 1, 32'h0);
        step(0, 1, 0, 0, 32'h0000_0000);
        step(0, 0, 1, 0, 32'h0);
        step(0, 0, 1, 0, 32'h0);
        chk("run on after wrap", 3, count_o, 32'hFFFF_FFFE, exc_o, 1'b1);

        // R1: reset in mid-run with exception pending
        @(negedge clk);
        rate_reload = 0; wr_en = 0; tick = 0; ack = 0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("reset mid-run", 1, count_o, 32'hFFFF_FFFF, exc_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 32'h0);
        chk("idle after reset", 1, count_o, 32'hFFFF_FFFF, exc_o, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule